// File: doc/BRIEF.md
# BCD Real-Time Clock Core

This core keeps time of day and a calendar in packed BCD. A free-running tick of 32768 Hz is divided down to one strobe per second. That strobe ripples through the seconds, minutes and hours fields, then through date, month and year. A separate day-of-week field advances on each day carry. The whole chain settles in the same clock cycle. The hours field can be kept in 24-hour or 12-hour form. In 12-hour form, one bit of the hour register carries the AM/PM flag. In 24-hour form, the same bit is the upper tens-of-hours bit. A stop flag in the seconds register freezes the whole chain and the divider.

A host reaches the registers through a parallel port. A write strobe with an address and a data byte loads one register. The read data follows the address combinationally. A serial front end or a bus adapter is expected to sit in front of this port.

Top module: `rtc_bcd_core`

Register addresses: 0 seconds (bit 7 = stop flag, bits 6:0 BCD seconds), 1 minutes (bits 6:0), 2 hours (bit 7 = 12-hour format when 1, bit 5 = PM in 12-hour format or tens-of-hours bit 1 in 24-hour format, bit 4 tens bit 0, bits 3:0 units), 3 date (bits 5:0), 4 month (bits 4:0), 5 day of week (bits 2:0), 6 year (bits 7:0), 7 unused.

## Requirements
- R1: After reset, the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, day of week 0x01 and year 0x00.
- R2: While the stop flag is clear, the seconds field advances once for every TICKS_PER_SEC cycles in which tick_i is high. Cycles with tick_i low do not count.
- R3: Seconds and minutes each count in BCD from 00 to 59. A rollover from 59 to 00 advances the next field in the same cycle.
- R4: In 24-hour format (hour bit 7 = 0), hours count 00 to 23. The step from 23 to 00 advances the date and the day of week.
- R5: In 12-hour format (hour bit 7 = 1), hours count 12, 01 … 11 in bits 4:0. The step from 11 to 12 toggles bit 5. Only the step from 11 PM to 12 AM advances the date.
- R6: Date rolls to 01 after day 28 in February, after day 30 in April, June, September and November, and after day 31 in all other months. The roll advances the month.
- R7: Month rolls from 12 to 01 and advances the year. The year counts in BCD from 00 to 99 and wraps to 00.
- R8: Day of week counts 1 to 7 and wraps to 1 on each day carry.
- R9: While bit 7 of the seconds register is 1, no field and no divider state changes except through host writes.
- R10: A host write to the seconds register clears the divider. The next second strobe then arrives after exactly TICKS_PER_SEC counted ticks.
- R11: A write loads the register selected by addr_i. Writing has these effects:
  - Bits that do not exist in that register read back as 0 (minutes mask 0x7F, hours mask 0xBF, day-of-week mask 0x07).
  - A write takes priority over any increment of the same register in the same cycle.
  - Address 7 always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per 32768 Hz period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the register at addr_i |

## Verification
The checker assumes that the host writes only legal BCD values. That means seconds and minutes at 59 or below, hours inside the range of the chosen format, and a date no larger than the current month's length. Its range properties on seconds, 24-hour hours, date and day of week depend on that assumption. The random stimulus draws every written value from these legal ranges. It drops any month write whose length would be shorter than the date already held. The masking checks that write out-of-range patterns restore legal values right away.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_REGS = 7;
  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HOUR = 3'd2;
  localparam logic [2:0] A_DATE = 3'd3;
  localparam logic [2:0] A_MON  = 3'd4;
  localparam logic [2:0] A_DOW  = 3'd5;
  localparam logic [2:0] A_YEAR = 3'd6;

  localparam logic [7:0] M_MIN  = 8'h7f;
  localparam logic [7:0] M_HOUR = 8'hbf;
  localparam logic [7:0] M_DATE = 8'h3f;
  localparam logic [7:0] M_MON  = 8'h1f;
  localparam logic [7:0] M_DOW  = 8'h07;

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon);
    case (mon)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_stb_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          step, wrap;

  assign step      = tick_i & run_i;
  assign wrap      = step & (cnt_q == LAST);
  assign sec_stb_o = wrap & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_stb_i,
  input  logic       wr_sec_i,
  input  logic       wr_min_i,
  input  logic       wr_hour_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_stb_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] sec_inc, h12_inc, h24_inc, hour_nx;
  logic       min_step, hour_step, hour_carry;

  assign sec_inc   = bcd_inc8({1'b0, sec_q[6:0]});
  assign h12_inc   = bcd_inc8({3'b0, hour_q[4:0]});
  assign h24_inc   = bcd_inc8({2'b0, hour_q[5:0]});
  assign min_step  = sec_stb_i & (sec_q[6:0] == 7'h59);
  assign hour_step = min_step & (min_q == 8'h59);
  assign day_stb_o = hour_step & hour_carry;

  always_comb begin
    hour_nx    = hour_q;
    hour_carry = 1'b0;
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx[4:0] = 5'h12;
        hour_nx[5]   = ~hour_q[5];
        hour_carry   = hour_q[5];     // PM -> AM
      end else if (hour_q[4:0] == 5'h12) begin
        hour_nx[4:0] = 5'h01;
      end else begin
        hour_nx[4:0] = h12_inc[4:0];
      end
    end else if (hour_q[5:0] == 6'h23) begin
      hour_nx[5:0] = 6'h00;
      hour_carry   = 1'b1;
    end else begin
      hour_nx[5:0] = h24_inc[5:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec_i)       sec_q <= wdata_i;
      else if (sec_stb_i) sec_q <= {sec_q[7], min_step ? 7'h00 : sec_inc[6:0]};

      if (wr_min_i)      min_q <= wdata_i & M_MIN;
      else if (min_step) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc8(min_q);

      if (wr_hour_i)      hour_q <= wdata_i & M_HOUR;
      else if (hour_step) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_stb_i,
  input  logic       wr_date_i,
  input  logic       wr_mon_i,
  input  logic       wr_dow_i,
  input  logic       wr_year_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] dow_o,
  output logic [7:0] year_o
);
  logic [7:0] date_q, mon_q, dow_q, year_q;
  logic       mon_step, year_step;

  assign mon_step  = day_stb_i & (date_q == month_last(mon_q));
  assign year_step = mon_step & (mon_q == 8'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_date_i)      date_q <= wdata_i & M_DATE;
      else if (day_stb_i) date_q <= mon_step ? 8'h01 : bcd_inc8(date_q);

      if (wr_mon_i)      mon_q <= wdata_i & M_MON;
      else if (mon_step) mon_q <= (mon_q == 8'h12) ? 8'h01 : bcd_inc8(mon_q);

      if (wr_dow_i)       dow_q <= wdata_i & M_DOW;
      else if (day_stb_i) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;

      if (wr_year_i)      year_q <= wdata_i;
      else if (year_step) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc8(year_q);
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign dow_o  = dow_q;
  assign year_o = year_q;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q;
  logic       sec_stb, day_stb;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr_dec
    assign wr_sel[g] = wr_en_i & (addr_i == 3'(g));
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (~sec_q[7]),
    .clear_i  (wr_sel[A_SEC]),
    .sec_stb_o(sec_stb)
  );

  rtc_time_chain i_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sec_stb_i(sec_stb),
    .wr_sec_i (wr_sel[A_SEC]),
    .wr_min_i (wr_sel[A_MIN]),
    .wr_hour_i(wr_sel[A_HOUR]),
    .wdata_i  (wdata_i),
    .sec_o    (sec_q),
    .min_o    (min_q),
    .hour_o   (hour_q),
    .day_stb_o(day_stb)
  );

  rtc_calendar i_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .day_stb_i(day_stb),
    .wr_date_i(wr_sel[A_DATE]),
    .wr_mon_i (wr_sel[A_MON]),
    .wr_dow_i (wr_sel[A_DOW]),
    .wr_year_i(wr_sel[A_YEAR]),
    .wdata_i  (wdata_i),
    .date_o   (date_q),
    .mon_o    (mon_q),
    .dow_o    (dow_q),
    .year_o   (year_q)
  );

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = sec_q;
      A_MIN:   rdata_o = min_q;
      A_HOUR:  rdata_o = hour_q;
      A_DATE:  rdata_o = date_q;
      A_MON:   rdata_o = mon_q;
      A_DOW:   rdata_o = dow_q;
      A_YEAR:  rdata_o = year_q;
      default: rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] dow_q,
  input logic       sec_stb,
  input logic       day_stb
);
  // R2
  stb_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb |-> (tick_i && !sec_q[7]));
  // R3
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q[6:0] <= 7'h59);
  // R4
  hour24_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hour_q[7] |-> hour_q[5:0] <= 6'h23);
  // R4
  day_from_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_stb |-> sec_stb);
  // R6
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_q != 8'h00) && (date_q <= 8'h31));
  // R8
  dow_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow_q >= 8'h01) && (dow_q <= 8'h07));
  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q[7] && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(date_q)));
  // R11
  min_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd1) |=> (min_q == ($past(wdata_i) & 8'h7f)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .sec_q  (sec_q),
  .min_q  (min_q),
  .hour_q (hour_q),
  .date_q (date_q),
  .dow_q  (dow_q),
  .sec_stb(sec_stb),
  .day_stb(day_stb)
);

// File: tb/test_rtc_bcd_core.sv
`timescale 1ns/10ps
module test_rtc_bcd_core;
  localparam int T = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_sec = 8'h00, m_min = 8'h00, m_hour = 8'h00, m_date = 8'h01;
  logic [7:0] m_mon = 8'h01, m_dow = 8'h01, m_year = 8'h00;
  int m_cnt = 0;

  always #2 clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(T)) i_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic [7:0] mlen(input logic [7:0] m);
    if (m == 8'h02) return 8'h28;
    if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // returns {day carry, next hour}
  function automatic logic [8:0] hour_next(input logic [7:0] h);
    logic [7:0] n;
    if (h[7]) begin
      n = h;
      case (h[4:0])
        5'h12: n[4:0] = 5'h01;
        5'h11: begin n[4:0] = 5'h12; n[5] = ~h[5]; return {h[5], n}; end
        default: n[4:0] = 5'(inc({3'b0, h[4:0]}));
      endcase
      return {1'b0, n};
    end
    if (h[5:0] == 6'h23) return {1'b1, 8'h00};
    return {1'b0, inc(h)};
  endfunction

  function automatic logic [7:0] model_val(input int a);
    case (a)
      0: return m_sec;   1: return m_min;  2: return m_hour; 3: return m_date;
      4: return m_mon;   5: return m_dow;  6: return m_year;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0, 1: return "R3";
      2: return "R4/R5";
      3: return "R6";
      4, 6: return "R7";
      5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic read_chk(input int a, input logic [7:0] exp, input string req);
    addr = a[2:0];
    #0.1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d act %h exp %h at %0t", req, a, rdata, exp, $time);
    end
  endtask

  task automatic cmp_all();
    for (int a = 0; a < 8; a++) read_chk(a, model_val(a), req_of(a));
  endtask

  task automatic model_step(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    logic stb, min_inc, hr_inc, day_inc, mon_inc, yr_inc;
    logic [8:0] hn;
    logic wsec;
    wsec    = w && a == 3'd0;
    stb     = t && !m_sec[7] && m_cnt == T - 1 && !wsec;
    if (wsec) m_cnt = 0;
    else if (t && !m_sec[7]) m_cnt = (m_cnt == T - 1) ? 0 : m_cnt + 1;
    min_inc = stb && m_sec[6:0] == 7'h59;
    hr_inc  = min_inc && m_min == 8'h59;
    hn      = hour_next(m_hour);
    day_inc = hr_inc && hn[8];
    mon_inc = day_inc && m_date == mlen(m_mon);
    yr_inc  = mon_inc && m_mon == 8'h12;
    if (stb)     m_sec  = min_inc ? {m_sec[7], 7'h00} : inc(m_sec);
    if (min_inc) m_min  = (m_min == 8'h59) ? 8'h00 : inc(m_min);
    if (hr_inc)  m_hour = hn[7:0];
    if (day_inc) m_date = mon_inc ? 8'h01 : inc(m_date);
    if (day_inc) m_dow  = (m_dow == 8'h07) ? 8'h01 : m_dow + 8'h01;
    if (mon_inc) m_mon  = (m_mon == 8'h12) ? 8'h01 : inc(m_mon);
    if (yr_inc)  m_year = (m_year == 8'h99) ? 8'h00 : inc(m_year);
    if (w) begin
      case (a)
        3'd0: m_sec  = d;
        3'd1: m_min  = d & 8'h7f;
        3'd2: m_hour = d & 8'hbf;
        3'd3: m_date = d & 8'h3f;
        3'd4: m_mon  = d & 8'h1f;
        3'd5: m_dow  = d & 8'h07;
        3'd6: m_year = d;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    tick = t; we = w; addr = a; wdata = d;
    model_step(t, w, a, d);
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    cmp_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic last_second(input logic [7:0] h);
    wr(3'd2, h); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(T);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic w;
    logic [2:0] a;
    logic [7:0] d;
    int r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_chk(0, 8'h00, "R1"); read_chk(1, 8'h00, "R1"); read_chk(2, 8'h00, "R1");
    read_chk(3, 8'h01, "R1"); read_chk(4, 8'h01, "R1"); read_chk(5, 8'h01, "R1");
    read_chk(6, 8'h00, "R1");

    // R2 idle ticks do nothing; R10 write clears divider
    wr(3'd0, 8'h10);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00);
    read_chk(0, 8'h10, "R2");
    run(T - 1); read_chk(0, 8'h10, "R10");
    run(1);     read_chk(0, 8'h11, "R10");
    run(T);     read_chk(0, 8'h12, "R2");

    // R4 and R8: 23:59:59 rolls into next day
    wr(3'd4, 8'h01); wr(3'd3, 8'h05); wr(3'd5, 8'h07);
    last_second(8'h23);
    read_chk(2, 8'h00, "R4"); read_chk(1, 8'h00, "R3"); read_chk(0, 8'h00, "R3");
    read_chk(3, 8'h06, "R4"); read_chk(5, 8'h01, "R8");

    // R5: 11 AM -> 12 PM, 11 PM -> 12 AM, 12 -> 01
    wr(3'd3, 8'h10);
    last_second(8'h91);
    read_chk(2, 8'hb2, "R5"); read_chk(3, 8'h10, "R5");
    last_second(8'hb1);
    read_chk(2, 8'h92, "R5"); read_chk(3, 8'h11, "R5");
    wr(3'd1, 8'h59); wr(3'd0, 8'h59); run(T);
    read_chk(2, 8'h81, "R5");

    // R6 month lengths
    wr(3'd4, 8'h02); wr(3'd3, 8'h28); last_second(8'h23);
    read_chk(3, 8'h01, "R6"); read_chk(4, 8'h03, "R6");
    wr(3'd4, 8'h04); wr(3'd3, 8'h30); last_second(8'h23);
    read_chk(3, 8'h01, "R6"); read_chk(4, 8'h05, "R6");
    wr(3'd4, 8'h01); wr(3'd3, 8'h30); last_second(8'h23);
    read_chk(3, 8'h31, "R6"); read_chk(4, 8'h01, "R6");

    // R7 year end wrap
    wr(3'd4, 8'h12); wr(3'd3, 8'h31); wr(3'd6, 8'h99); last_second(8'h23);
    read_chk(3, 8'h01, "R7"); read_chk(4, 8'h01, "R7"); read_chk(6, 8'h00, "R7");

    // R9 halt freezes everything
    wr(3'd1, 8'h20); wr(3'd0, 8'h85);
    run(2 * T + 1);
    read_chk(0, 8'h85, "R9"); read_chk(1, 8'h20, "R9");
    wr(3'd0, 8'h05); run(T - 1); read_chk(0, 8'h05, "R9");
    run(1); read_chk(0, 8'h06, "R9");

    // R11 masks, unused address, write priority
    wr(3'd1, 8'hff); read_chk(1, 8'h7f, "R11");
    wr(3'd2, 8'hff); read_chk(2, 8'hbf, "R11");
    wr(3'd5, 8'hff); read_chk(5, 8'h07, "R11");
    wr(3'd7, 8'haa); read_chk(7, 8'h00, "R11");
    wr(3'd2, 8'h00); wr(3'd1, 8'h10); wr(3'd0, 8'h59);
    run(T - 1);
    cyc(1'b1, 1'b1, 3'd1, 8'h30);
    read_chk(0, 8'h00, "R11"); read_chk(1, 8'h30, "R11");

    // random mix, checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      w = ($urandom % 12) == 0;
      a = 3'($urandom % 8);
      d = 8'h00;
      case (a)
        3'd0: d = {($urandom % 8) == 0, (($urandom % 3) == 0) ? 7'h59 : 7'(to_bcd($urandom % 60))};
        3'd1: d = (($urandom % 3) == 0) ? 8'h59 : to_bcd($urandom % 60);
        3'd2: if ($urandom % 2) begin
                r = 1 + $urandom % 12;
                if ($urandom % 2) r = 11;
                d = {1'b1, 1'($urandom % 2), 1'b0, 5'(to_bcd(r))};
              end else d = (($urandom % 2) == 0) ? 8'h23 : to_bcd($urandom % 24);
        3'd3: begin
                r = from_bcd(mlen(m_mon));
                d = (($urandom % 2) == 0) ? mlen(m_mon) : to_bcd(1 + $urandom % r);
              end
        3'd4: begin
                d = (($urandom % 3) == 0) ? 8'h12 : to_bcd(1 + $urandom % 12);
                if (mlen(d) < m_date) w = 1'b0;
              end
        3'd5: d = 8'(1 + $urandom % 7);
        3'd6: d = (($urandom % 3) == 0) ? 8'h99 : to_bcd($urandom % 100);
        default: d = 8'($urandom);
      endcase
      cyc(($urandom % 4) != 0, w, a, d);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule